// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

The block is one memory-to-memory copy channel. Software loads a source address, a destination address, a byte count and a control word through a small word-addressed register port. A transfer is launched by a hardware request line or by a software start strobe. Each iteration reads one unit from the source over a single-beat memory bus, writes the same unit to the destination, then steps the byte count down by the unit size. Each address may advance after the write, under its own increment enable.

In per-request mode each accepted request moves exactly one unit. In run-to-completion mode a request keeps the channel moving until the count reaches zero. In that mode, clearing the request enable parks the channel, and setting the enable again resumes it from where it stopped. Status flags share a word with the live byte count, and an optional interrupt reports completion. Bad setups are rejected before any bus access. Bus errors halt the channel and are reported.

Top module: `dma_engine`

## Requirements
- R1: After reset the status word, the control word, `irq_o` and `mem_req_o` are all zero.
- R2: Register word index `reg_addr_i[3:2]` selects the register: 0 is the source address, 1 is the destination address, 2 is status/count and 3 is control. The address registers read back as written. In the status word, bits [23:0] hold the remaining byte count.
- R3: The unit code is 0 for 4 bytes, 1 for 1 byte and 2 for 2 bytes. Each successful write lowers the byte count by the unit size.
- R4: Each iteration performs one read at the source address and then one write of the data just read to the destination address. `mem_size_o` carries the unit code. A request holds its address and direction until `mem_ack_i`.
- R5: Control bit 3 enables the source address to advance by its unit after each iteration, and control bit 4 does the same for the destination address. With an enable clear, that address stays fixed.
- R6: With control bit 2 (per-request) set, each accepted request performs exactly one read/write pair. Busy (status bit 25) stays high between pairs while the count is not zero.
- R7: With control bit 2 clear and control bit 1 (request enable) set, one pulse on `xfer_req_i` moves the whole count.
- R8: Writing the control word with bit 9 set launches one read/write pair. `xfer_req_i` is ignored while control bit 1 is clear.
- R9: Clearing control bit 1 during a run-to-completion transfer stops it after the current pair, with the count and busy held. Setting the bit again resumes the transfer to completion from the held addresses and count.
- R10: At launch, any of the following sets the configuration error (bit 29) and done (bit 24) and causes no bus access: a zero count, a count that is not a multiple of the unit, unequal source and destination unit codes (control [6:5] and [8:7]), or unit code 3.
- R11: An error response on a read sets bit 28, and an error response on a write sets bit 27. Either error sets done, clears busy and stops bus activity, and the failed iteration does not change the count.
- R12: Busy rises on launch and falls when the count reaches zero. Done (bit 24) rises in the cycle after the final write is acknowledged.
- R13: Writing the status word with bit 24 set clears done, the error flags and the pending request (bit 26), and leaves the count unchanged. While done is set, starts and hardware requests are ignored.
- R14: `irq_o` is high exactly when done is set and control bit 0 (interrupt enable) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| xfer_req_i | input | 1 | Hardware transfer request |
| mem_req_o | output | 1 | Bus access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Access address |
| mem_size_o | output | 2 | Unit code of the access |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_err_i | input | 1 | Completing access failed |
| irq_o | output | 1 | Completion interrupt |

## Verification
The hardest state to reach is a run-to-completion transfer parked mid-block. Reaching it needs a control write to land while bus accesses are in flight, and the run must then resume with no lost or repeated unit. The bench stretches bus latency at random, drops the request enable part way through a long byte-wide copy, and confirms that the count stays frozen with busy held. It then compares the full access trace after resuming against the uninterrupted sequence. Error responses are injected on a chosen access index, so a read fault and a write fault each land mid-block.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_state_e;

  localparam logic [1:0] IDX_SRC  = 2'd0;
  localparam logic [1:0] IDX_DST  = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;
  localparam logic [1:0] IDX_CTRL = 2'd3;

  localparam int FLAG_LSB  = 24;
  localparam int START_BIT = 9;
  localparam int CTRL_W    = 9;

  // packs to bits [5:0]: done is bit 0
  typedef struct packed {
    logic cfg_err;
    logic src_err;
    logic dst_err;
    logic pend;
    logic busy;
    logic done;
  } flags_t;

  typedef struct packed {
    logic [1:0] dst_unit;
    logic [1:0] src_unit;
    logic       dst_inc;
    logic       src_inc;
    logic       steal;
    logic       req_en;
    logic       irq_en;
  } ctrl_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd4;
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic              inc_i,
  input  logic [1:0]        unit_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              addr_q <= '0;
    else if (load_i)          addr_q <= load_val_i;
    else if (step_i && inc_i) addr_q <= addr_q + ADDR_W'(unit_bytes(unit_i));
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_byte_count.sv
module dma_byte_count
  import dma_eng_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic [1:0]       src_unit_i,
  input  logic [1:0]       dst_unit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             cfg_bad_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ub;
  logic [CNT_W-1:0] misalign;

  assign ub       = CNT_W'(unit_bytes(src_unit_i));
  assign misalign = cnt_q & (ub - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_q - ub;
  end

  assign cnt_o     = cnt_q;
  assign last_o    = (cnt_q == ub);
  assign cfg_bad_o = (src_unit_i != dst_unit_i) || (ub == '0) ||
                     (cnt_q == '0) || (misalign != '0);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_eng_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   hreq_i,
  input  logic   req_en_i,
  input  logic   steal_i,
  input  logic   clear_i,
  input  logic   cfg_bad_i,
  input  logic   last_i,
  input  logic   mem_ack_i,
  input  logic   mem_err_i,
  output logic   rd_o,
  output logic   wr_o,
  output logic   rd_ok_o,
  output logic   step_o,
  output flags_t flags_o
);

  seq_state_e st_q;
  flags_t     fl_q;
  logic       launch;

  // a parked continuous run restarts on its own once requests are enabled again
  assign launch = (st_q == ST_IDLE) && !fl_q.done &&
                  (fl_q.pend || (fl_q.busy && !steal_i && req_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      fl_q <= '0;
    end else begin
      if (clear_i) begin
        fl_q.done    <= 1'b0;
        fl_q.src_err <= 1'b0;
        fl_q.dst_err <= 1'b0;
        fl_q.cfg_err <= 1'b0;
        fl_q.pend    <= 1'b0;
      end
      if (!fl_q.done && (start_i || hreq_i)) fl_q.pend <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (launch) begin
            fl_q.pend <= 1'b0;
            if (cfg_bad_i) begin
              fl_q.cfg_err <= 1'b1;
              fl_q.done    <= 1'b1;
              fl_q.busy    <= 1'b0;
            end else begin
              fl_q.busy <= 1'b1;
              st_q      <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_ack_i) begin
            if (mem_err_i) begin
              fl_q.src_err <= 1'b1;
              fl_q.done    <= 1'b1;
              fl_q.busy    <= 1'b0;
              fl_q.pend    <= 1'b0;
              st_q         <= ST_IDLE;
            end else begin
              st_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack_i) begin
            if (mem_err_i) begin
              fl_q.dst_err <= 1'b1;
              fl_q.done    <= 1'b1;
              fl_q.busy    <= 1'b0;
              fl_q.pend    <= 1'b0;
              st_q         <= ST_IDLE;
            end else if (last_i) begin
              fl_q.done <= 1'b1;
              fl_q.busy <= 1'b0;
              fl_q.pend <= 1'b0;
              st_q      <= ST_IDLE;
            end else if (!steal_i && req_en_i) begin
              st_q <= ST_READ;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o    = (st_q == ST_READ);
  assign wr_o    = (st_q == ST_WRITE);
  assign rd_ok_o = rd_o && mem_ack_i && !mem_err_i;
  assign step_o  = wr_o && mem_ack_i && !mem_err_i;
  assign flags_o = fl_q;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              xfer_req_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic              irq_o
);

  localparam int SIDES = 2;

  logic [1:0]        idx;
  ctrl_t             ctrl_q;
  flags_t            flags;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              cnt_load, clear, start, hreq;
  logic              rd, wr, rd_ok, step, last, cfg_bad;
  logic [ADDR_W-1:0] side_addr [SIDES];
  logic              side_load [SIDES];
  logic              side_inc  [SIDES];
  logic [1:0]        side_unit [SIDES];
  logic [1:0]        unused_addr_lsb;

  assign idx             = reg_addr_i[3:2];
  assign unused_addr_lsb = reg_addr_i[1:0];
  assign cnt_load = reg_we_i && (idx == IDX_STAT) && !reg_wdata_i[FLAG_LSB];
  assign clear    = reg_we_i && (idx == IDX_STAT) &&  reg_wdata_i[FLAG_LSB];
  assign start    = reg_we_i && (idx == IDX_CTRL) &&  reg_wdata_i[START_BIT];
  assign hreq     = xfer_req_i && ctrl_q.req_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ctrl_q <= '0;
    else if (reg_we_i && idx == IDX_CTRL)  ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (rd_ok) data_q <= mem_rdata_i;
  end

  assign side_load[0] = reg_we_i && (idx == IDX_SRC);
  assign side_load[1] = reg_we_i && (idx == IDX_DST);
  assign side_inc[0]  = ctrl_q.src_inc;
  assign side_inc[1]  = ctrl_q.dst_inc;
  assign side_unit[0] = ctrl_q.src_unit;
  assign side_unit[1] = ctrl_q.dst_unit;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma_addr_step #(.ADDR_W(ADDR_W)) i_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (side_load[s]),
      .load_val_i (reg_wdata_i[ADDR_W-1:0]),
      .step_i     (step),
      .inc_i      (side_inc[s]),
      .unit_i     (side_unit[s]),
      .addr_o     (side_addr[s])
    );
  end

  dma_byte_count #(.CNT_W(CNT_W)) i_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .step_i     (step),
    .src_unit_i (ctrl_q.src_unit),
    .dst_unit_i (ctrl_q.dst_unit),
    .cnt_o      (cnt_q),
    .last_o     (last),
    .cfg_bad_o  (cfg_bad)
  );

  dma_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .hreq_i    (hreq),
    .req_en_i  (ctrl_q.req_en),
    .steal_i   (ctrl_q.steal),
    .clear_i   (clear),
    .cfg_bad_i (cfg_bad),
    .last_i    (last),
    .mem_ack_i (mem_ack_i),
    .mem_err_i (mem_err_i),
    .rd_o      (rd),
    .wr_o      (wr),
    .rd_ok_o   (rd_ok),
    .step_o    (step),
    .flags_o   (flags)
  );

  assign mem_req_o   = rd || wr;
  assign mem_we_o    = wr;
  assign mem_addr_o  = rd ? side_addr[0] : side_addr[1];
  assign mem_size_o  = rd ? ctrl_q.src_unit : ctrl_q.dst_unit;
  assign mem_wdata_o = data_q;
  assign irq_o       = flags.done && ctrl_q.irq_en;

  always_comb begin
    reg_rdata_o = '0;
    case (idx)
      IDX_SRC:  reg_rdata_o = 32'(side_addr[0]);
      IDX_DST:  reg_rdata_o = 32'(side_addr[1]);
      IDX_STAT: begin
        reg_rdata_o[CNT_W-1:0]          = cnt_q;
        reg_rdata_o[FLAG_LSB+5:FLAG_LSB] = flags;
      end
      default:  reg_rdata_o[CTRL_W-1:0] = ctrl_q;
    endcase
  end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              mem_err_i,
  input logic              irq_o,
  input flags_t            flags_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [1:0]        src_unit_i
);

  assert_hold_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !reg_we_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i && !mem_err_i && !reg_we_i
    |=> cnt_i == $past(cnt_i) - CNT_W'(unit_bytes($past(src_unit_i))));

  assert_cfg_no_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i.cfg_err) |-> !mem_req_o && !flags_i.busy);

  assert_err_halts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && mem_err_i |=> flags_i.done && !mem_req_o && !flags_i.busy);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i.done) |-> !flags_i.busy && !mem_req_o);

  assert_irq_needs_done_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags_i.done);

endmodule

bind dma_engine dma_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .mem_err_i  (mem_err_i),
  .irq_o      (irq_o),
  .flags_i    (flags),
  .cnt_i      (cnt_q),
  .src_unit_i (ctrl_q.src_unit)
);

// File: tb/test_dma_engine.sv
module test_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam int B_DONE = 24, B_BUSY = 25, B_DERR = 27, B_SERR = 28, B_CERR = 29;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_req = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [31:0] lg_addr [256];
  logic [31:0] lg_data [256];
  logic        lg_we   [256];
  logic [1:0]  lg_size [256];
  int n_log = 0;
  int lat_max = 1;
  int err_idx = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_engine i_dma_engine (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .xfer_req_i(xfer_req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .irq_o(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC3A5_5A3C;
  endfunction

  function automatic int ubytes(input logic [1:0] u);
    return (u == 2'd0) ? 4 : (u == 2'd1) ? 1 : (u == 2'd2) ? 2 : 0;
  endfunction

  function automatic logic [31:0] cw(input bit ie, re, st, si, di,
                                     input logic [1:0] su, du, input bit go);
    return {22'd0, go, du, su, di, si, st, re, ie};
  endfunction

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus responder with random wait states and optional error on one access index
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      mem_err = 1'b0;
      if (mem_req) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          mem_ack = 1'b1;
          mem_err = (n_log == err_idx);
          mem_rdata = pat(mem_addr);
          if (n_log < 256) begin
            lg_addr[n_log] = mem_addr;
            lg_we[n_log]   = mem_we;
            lg_data[n_log] = mem_wdata;
            lg_size[n_log] = mem_size;
          end
          n_log++;
          wait_cnt = $urandom % (lat_max + 1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr_reg(input logic [1:0] idx, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {idx, 2'b00}; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] idx, output logic [31:0] v);
    @(negedge clk);
    reg_addr = {idx, 2'b00};
    #1 v = reg_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic wait_done(input int max);
    logic [31:0] s;
    for (int i = 0; i < max; i++) begin
      rd_reg(2'd2, s);
      if (s[B_DONE]) break;
    end
  endtask

  task automatic clear_flags();
    wr_reg(2'd2, 32'h1 << B_DONE);
  endtask

  task automatic load(input logic [31:0] s, d, c);
    wr_reg(2'd0, s); wr_reg(2'd1, d); wr_reg(2'd2, c);
  endtask

  task automatic check_log(input string tag, input logic [31:0] s, d, input int n,
                           input logic [1:0] u, input bit si, di);
    int mism = 0;
    int ub = ubytes(u);
    if (n_log != 2 * n) mism++;
    for (int k = 0; k < n && 2 * k + 1 < n_log; k++) begin
      logic [31:0] ra, wa;
      ra = s + (si ? 32'(k * ub) : 32'd0);
      wa = d + (di ? 32'(k * ub) : 32'd0);
      if (lg_we[2*k] !== 1'b0 || lg_addr[2*k] !== ra || lg_size[2*k] !== u) mism++;
      if (lg_we[2*k+1] !== 1'b1 || lg_addr[2*k+1] !== wa || lg_size[2*k+1] !== u ||
          lg_data[2*k+1] !== pat(ra)) mism++;
    end
    chk_eq(tag, 32'(mism), 32'd0);
  endtask

  initial begin
    logic [31:0] v, c1, c2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_reg(2'd2, v); chk_eq("R1 status after reset", v, 32'd0);
    rd_reg(2'd3, v); chk_eq("R1 control after reset", v, 32'd0);
    chk_eq("R1 irq after reset", 32'(irq), 32'd0);
    chk_eq("R1 no bus request after reset", 32'(mem_req), 32'd0);

    // R2 register map
    load(32'h0000_1000, 32'h0000_2000, 32'd16);
    rd_reg(2'd0, v); chk_eq("R2 source readback", v, 32'h0000_1000);
    rd_reg(2'd1, v); chk_eq("R2 destination readback", v, 32'h0000_2000);
    rd_reg(2'd2, v); chk_eq("R2 count readback", v, 32'd16);

    // R7 run to completion from one hardware pulse
    n_log = 0; lat_max = 2;
    wr_reg(2'd3, cw(1, 1, 0, 1, 1, 2'd0, 2'd0, 0));
    pulse_req();
    wait_done(200);
    check_log("R7 R3 R4 R5 word copy trace", 32'h1000, 32'h2000, 4, 2'd0, 1, 1);
    rd_reg(2'd2, v); chk_eq("R12 done set, busy clear, count zero", v, 32'h1 << B_DONE);
    chk_eq("R14 irq with done and enable", 32'(irq), 32'd1);

    // R13 clear keeps count
    wr_reg(2'd2, (32'h1 << B_DONE) | 32'h55);
    rd_reg(2'd2, v); chk_eq("R13 clear all flags, count untouched", v, 32'd0);
    chk_eq("R14 irq drops after clear", 32'(irq), 32'd0);

    // R6 per-request mode, fixed destination
    load(32'h0000_3000, 32'h0000_4000, 32'd6);
    n_log = 0;
    wr_reg(2'd3, cw(0, 1, 1, 1, 0, 2'd2, 2'd2, 0));
    pulse_req();
    repeat (20) @(negedge clk);
    chk_eq("R6 one pair per request", 32'(n_log), 32'd2);
    rd_reg(2'd2, v); chk_eq("R6 busy held, count stepped by 2", v, (32'h1 << B_BUSY) | 32'd4);
    pulse_req(); repeat (20) @(negedge clk);
    pulse_req();
    wait_done(200);
    check_log("R6 R5 halfword trace, fixed destination", 32'h3000, 32'h4000, 3, 2'd2, 1, 0);
    clear_flags();

    // R8 start strobe and ignored hardware request, R9 resume
    load(32'h0000_5000, 32'h0000_6000, 32'd8);
    n_log = 0;
    wr_reg(2'd3, cw(0, 0, 0, 1, 1, 2'd1, 2'd1, 1));
    repeat (20) @(negedge clk);
    chk_eq("R8 start gives one pair", 32'(n_log), 32'd2);
    rd_reg(2'd2, v); chk_eq("R8 count after start", v, (32'h1 << B_BUSY) | 32'd7);
    pulse_req(); repeat (20) @(negedge clk);
    chk_eq("R8 request ignored while disabled", 32'(n_log), 32'd2);
    wr_reg(2'd3, cw(0, 1, 0, 1, 1, 2'd1, 2'd1, 0));
    wait_done(300);
    check_log("R9 resume byte trace", 32'h5000, 32'h6000, 8, 2'd1, 1, 1);
    clear_flags();

    // R9 pause mid-run and resume
    load(32'h0000_7000, 32'h0000_8000, 32'd40);
    n_log = 0; lat_max = 3;
    wr_reg(2'd3, cw(0, 1, 0, 1, 1, 2'd1, 2'd1, 0));
    pulse_req();
    repeat (15) @(negedge clk);
    wr_reg(2'd3, cw(0, 0, 0, 1, 1, 2'd1, 2'd1, 0));
    repeat (20) @(negedge clk);
    rd_reg(2'd2, c1);
    repeat (10) @(negedge clk);
    rd_reg(2'd2, c2);
    chk_eq("R9 count frozen while paused", c2, c1);
    chk_eq("R9 busy held while paused", 32'(c1[B_BUSY]), 32'd1);
    chk_eq("R9 paused before end", 32'(c1[23:0] == 24'd0), 32'd0);
    wr_reg(2'd3, cw(0, 1, 0, 1, 1, 2'd1, 2'd1, 0));
    wait_done(1000);
    check_log("R9 paused trace matches uninterrupted", 32'h7000, 32'h8000, 40, 2'd1, 1, 1);
    clear_flags();

    // R10 configuration errors
    for (int t = 0; t < 4; t++) begin
      logic [31:0] cnt;
      logic [1:0] su, du;
      cnt = (t == 0) ? 32'd0 : (t == 1) ? 32'd6 : 32'd4;
      su  = (t == 2) ? 2'd1 : (t == 3) ? 2'd3 : 2'd0;
      du  = (t == 2) ? 2'd2 : (t == 3) ? 2'd3 : 2'd0;
      wr_reg(2'd2, cnt);
      n_log = 0;
      wr_reg(2'd3, cw(0, 0, 0, 1, 1, su, du, 1));
      repeat (10) @(negedge clk);
      rd_reg(2'd2, v);
      chk_eq("R10 config error flags", v, (32'h1 << B_CERR) | (32'h1 << B_DONE) | cnt);
      chk_eq("R10 no bus access on config error", 32'(n_log), 32'd0);
      clear_flags();
    end

    // R11 read error on second iteration
    load(32'h0000_9000, 32'h0000_A000, 32'd12);
    n_log = 0; err_idx = 2; lat_max = 1;
    wr_reg(2'd3, cw(1, 1, 0, 1, 1, 2'd0, 2'd0, 0));
    pulse_req();
    wait_done(200);
    repeat (5) @(negedge clk);
    rd_reg(2'd2, v);
    chk_eq("R11 source error status", v, (32'h1 << B_SERR) | (32'h1 << B_DONE) | 32'd8);
    chk_eq("R11 activity stops after read error", 32'(n_log), 32'd3);
    chk_eq("R14 irq on error done", 32'(irq), 32'd1);
    clear_flags();

    // R11 write error on first iteration
    load(32'h0000_9000, 32'h0000_A000, 32'd12);
    n_log = 0; err_idx = 1;
    pulse_req();
    wait_done(200);
    repeat (5) @(negedge clk);
    err_idx = -1;
    rd_reg(2'd2, v);
    chk_eq("R11 destination error status", v, (32'h1 << B_DERR) | (32'h1 << B_DONE) | 32'd12);

    // R13 requests ignored while done
    n_log = 0;
    pulse_req();
    wr_reg(2'd3, cw(1, 1, 0, 1, 1, 2'd0, 2'd0, 1));
    repeat (10) @(negedge clk);
    chk_eq("R13 no access while done", 32'(n_log), 32'd0);
    rd_reg(2'd2, v);
    chk_eq("R13 status unchanged while done", v, (32'h1 << B_DERR) | (32'h1 << B_DONE) | 32'd12);
    clear_flags();

    // random copies in run-to-completion mode
    for (int r = 0; r < 16; r++) begin
      logic [1:0] u;
      logic [31:0] s, d;
      bit si, di;
      int n;
      u  = 2'($urandom % 3);
      n  = 1 + int'($urandom % 6);
      si = 1'($urandom); di = 1'($urandom);
      s  = {16'd0, 16'($urandom)} & ~32'h3;
      d  = {16'd1, 16'($urandom)} & ~32'h3;
      lat_max = int'($urandom % 4);
      load(s, d, 32'(n * ubytes(u)));
      n_log = 0;
      wr_reg(2'd3, cw(0, 1, 0, si, di, u, u, 0));
      pulse_req();
      wait_done(400);
      check_log("R3 R4 R5 R7 random trace", s, d, n, u, si, di);
      rd_reg(2'd2, v); chk_eq("R12 random end status", v, 32'h1 << B_DONE);
      clear_flags();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule